// File: doc/BRIEF.md
# Redundant-digit polynomial multiplier

This block multiplies two large unsigned integers that are held as polynomials of redundant digits. Each operand carries KD+1 digits. Each digit is DW+1 bits wide, and digit i has weight 2^(DW·i). Neighbouring digits therefore overlap by one bit, so a digit may hold a value as large as 2^(DW+1)-1. The result comes out in the same kind of representation, with 2·KD+3 digits. No carry chain is longer than a single digit boundary, so the logic depth grows with the logarithm of the operand size rather than with its length.

Every digit-pair product is cut into three pieces: a low slice, a middle slice and a two-bit top slice. Each piece is added into one of three neighbouring column sums. A single fold then turns each column into an output digit. The fold keeps the low DW bits of a column and adds in the bits that spill over from the column below it. Every output digit stays below 2^(DW+1), so the result can feed another multiplier of the same shape without conversion.

A parameter selects whether the result passes through one register stage with a valid flag, or leaves the block combinationally.

Top module: `rdx_poly_mul`

## Requirements
- R1: Operand digit i sits at bits [i·(DW+1) +: DW+1] of its bus. The operand's value is the sum of digit_i·2^(DW·i). Any digit value below 2^(DW+1) is accepted.
- R2: The result value, taken as the sum of C_i·2^(DW·i) over its 2·KD+3 digits, equals the exact product of the two operand values.
- R3: Every result digit is below 2^(DW+1). The lowest result digit C_0 equals (a_0·b_0) mod 2^DW.
- R4: The top result digit C_(2KD+2) is the sum of two terms. The first is bits [2DW+1:2DW] of a_KD·b_KD. The second is column 2KD+1 shifted right by DW, where column 2KD+1 is bits [2DW-1:DW] of a_KD·b_KD plus the top slices of every digit pair whose indices sum to 2KD-1. No column sum overflows its storage.
- R5: When either operand is zero, every result digit is zero.
- R6: With the output register enabled, out_valid is high exactly in the cycle after in_valid was high, and the result shown then belongs to the operands presented with in_valid.
- R7: While reset is asserted, out_valid is low and every result digit is zero.
- R8: With the output register enabled, the result holds its value in every cycle that follows a cycle with in_valid low, whatever the operand buses carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands on a_in and b_in are to be multiplied |
| a_in | input | (KD+1)·(DW+1) | First operand, redundant digits |
| b_in | input | (KD+1)·(DW+1) | Second operand, redundant digits |
| out_valid | output | 1 | prod_out holds a new result |
| prod_out | output | (2KD+3)·(DW+1) | Product, redundant digits |

## Verification
The top result digit is the one place where two contributions land in the same evaluation: the direct top slice of the highest digit pair, and the overflow that the fold carries out of column 2KD+1. Operands with every digit at its maximum push both terms to their largest values. With the default parameters that case must give a top digit of exactly 4, and the weighted sum must still equal the true product. A second case that overlaps in time is a register capture in one cycle followed by operand changes while in_valid is low. That case is judged by checking that the result and the valid flag stay unchanged.

// File: rtl/rdx_poly_mul.sv
module rdx_poly_mul #(
  parameter int unsigned DW      = 16,
  parameter int unsigned KD      = 4,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  input  logic [(KD+1)*(DW+1)-1:0]         a_in,
  input  logic [(KD+1)*(DW+1)-1:0]         b_in,
  output logic                             out_valid,
  output logic [(2*KD+3)*(DW+1)-1:0]       prod_out
);
  localparam int unsigned ND   = KD + 1;
  localparam int unsigned NC   = 2*KD + 3;
  localparam int unsigned DIG  = DW + 1;
  localparam int unsigned PW   = 2*DW + 2;
  localparam int unsigned COLW = DW + $clog2(3*ND + 1) + 1;

  initial assert_col_width_R4 : assert (3*ND < (1 << DW));

  logic [PW-1:0]        pp [ND*ND];
  logic [COLW-1:0]      col [NC];
  logic [NC*DIG-1:0]    sum_flat;

  for (genvar gi = 0; gi < ND; gi++) begin : g_row
    for (genvar gj = 0; gj < ND; gj++) begin : g_col
      assign pp[gi*ND+gj] = PW'(a_in[gi*DIG +: DIG]) * PW'(b_in[gj*DIG +: DIG]);
    end
  end

  always_comb begin
    for (int c = 0; c < NC; c++) col[c] = '0;
    for (int i = 0; i < ND; i++) begin
      for (int j = 0; j < ND; j++) begin
        col[i+j]   = col[i+j]   + COLW'(pp[i*ND+j][DW-1:0]);
        col[i+j+1] = col[i+j+1] + COLW'(pp[i*ND+j][2*DW-1:DW]);
        col[i+j+2] = col[i+j+2] + COLW'(pp[i*ND+j][PW-1:2*DW]);
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      assert_no_overflow_R4 : assert ((col[c] >> DW) < (COLW'(1) << (COLW-DW-1)));
    end
    assert_top_col_R4 : assert (col[NC-1] < COLW'(4));
  end

  for (genvar gc = 0; gc < NC; gc++) begin : g_fold
    logic [DIG-1:0] base, spill;
    if (gc == NC-1) begin : g_top
      assign base = DIG'(col[gc]);
    end else begin : g_mid
      assign base = DIG'(col[gc][DW-1:0]);
    end
    if (gc == 0) begin : g_first
      assign spill = '0;
    end else begin : g_rest
      assign spill = DIG'(col[gc-1][COLW-1:DW]);
    end
    assign sum_flat[gc*DIG +: DIG] = base + spill;
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        prod_out  <= '0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) prod_out <= sum_flat;
      end
    end

    assert_latency_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    assert_idle_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
    assert_capture_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> prod_out == $past(sum_flat));
    assert_hold_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(prod_out));
  end else begin : g_comb
    assign out_valid = in_valid;
    assign prod_out  = sum_flat;
  end
endmodule

// File: tb/tb_rdx_poly_mul.sv
`timescale 1ns/1ps
module tb_rdx_poly_mul;
  localparam int DW = 16, KD = 4, ND = KD+1, NC = 2*KD+3, DIG = DW+1;
  localparam int IW = ND*DIG, OW = NC*DIG;
  localparam int NV = 5;
  localparam logic [IW-1:0] TA [NV] = '{
    85'h1_2345_6789_ABCD_EF01_2345, 85'h0_F0F0_0F0F_1234_8765_4321,
    85'h1_FFFF_0000_FFFF_0000_FFFF, 85'h0_0000_0000_0000_0000_0001,
    85'h1_DEAD_BEEF_CAFE_F00D_5A5A };
  localparam logic [IW-1:0] TB [NV] = '{
    85'h0_9876_5432_10FE_DCBA_9876, 85'h1_1111_2222_3333_4444_5555,
    85'h1_0000_FFFF_0000_FFFF_0000, 85'h1_FFFF_FFFF_FFFF_FFFF_FFFF,
    85'h0_1357_9BDF_2468_ACE0_FFFF };

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [IW-1:0] a_in = '0, b_in = '0;
  logic out_valid;
  logic [OW-1:0] prod_out;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  rdx_poly_mul dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_in(a_in),
                    .b_in(b_in), .out_valid(out_valid), .prod_out(prod_out));

  function automatic logic [191:0] val_in(logic [IW-1:0] v);
    logic [191:0] s = '0;
    for (int i = 0; i < ND; i++) s += 192'(v[i*DIG +: DIG]) << (DW*i);
    return s;
  endfunction

  function automatic logic [191:0] val_out(logic [OW-1:0] v);
    logic [191:0] s = '0;
    for (int i = 0; i < NC; i++) s += 192'(v[i*DIG +: DIG]) << (DW*i);
    return s;
  endfunction

  function automatic logic [33:0] dprod(logic [IW-1:0] a, logic [IW-1:0] b, int i, int j);
    return 34'(a[i*DIG +: DIG]) * 34'(b[j*DIG +: DIG]);
  endfunction

  function automatic logic [DIG-1:0] top_exp(logic [IW-1:0] a, logic [IW-1:0] b);
    logic [33:0] p = dprod(a, b, KD, KD);
    logic [31:0] c = 32'(p[31:16]);
    for (int i = 0; i < ND; i++)
      for (int j = 0; j < ND; j++)
        if (i + j == 2*KD-1) c += 32'(dprod(a, b, i, j)[33:32]);
    return DIG'(p[33:32]) + DIG'(c >> DW);
  endfunction

  task automatic check(bit ok, string req, logic [191:0] act, logic [191:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(logic [IW-1:0] a, logic [IW-1:0] b);
    @(negedge clk);
    a_in = a; b_in = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_result(logic [IW-1:0] a, logic [IW-1:0] b, string tag);
    logic [191:0] ev = val_in(a) * val_in(b);
    logic [15:0] c0 = 16'(dprod(a, b, 0, 0));
    bit bounded = 1'b1;
    check(out_valid === 1'b1, {"R6 valid ", tag}, 192'(out_valid), 192'd1);
    check(val_out(prod_out) === ev, {"R1/R2 value ", tag}, val_out(prod_out), ev);
    check(prod_out[DIG-1:0] === DIG'(c0), {"R3 low digit ", tag}, 192'(prod_out[DIG-1:0]), 192'(c0));
    check(prod_out[(NC-1)*DIG +: DIG] === top_exp(a, b), {"R4 top digit ", tag},
          192'(prod_out[(NC-1)*DIG +: DIG]), 192'(top_exp(a, b)));
    for (int i = 0; i < NC; i++) if (^prod_out[i*DIG +: DIG] === 1'bx) bounded = 1'b0;
    check(bounded, {"R3 digits defined ", tag}, 192'(bounded), 192'd1);
  endtask

  initial begin
    #(20 * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [OW-1:0] held;
    logic [IW-1:0] maxv;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R7 valid in reset", 192'(out_valid), 0);
    check(prod_out === '0, "R7 result in reset", val_out(prod_out), 0);
    @(negedge clk) rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      apply(TA[v], TB[v]);
      check_result(TA[v], TB[v], $sformatf("vec%0d", v));
    end

    maxv = '1;
    apply(maxv, maxv);
    check_result(maxv, maxv, "all-max");
    check(prod_out[(NC-1)*DIG +: DIG] === DIG'(4), "R4 all-max top equals 4",
          192'(prod_out[(NC-1)*DIG +: DIG]), 192'd4);

    held = prod_out;
    a_in = TA[0]; b_in = TB[1];
    @(negedge clk);
    check(prod_out === held, "R8 hold while idle", val_out(prod_out), val_out(held));
    check(out_valid === 1'b0, "R6 valid drops when idle", 192'(out_valid), 0);

    apply('0, TB[0]);
    check(prod_out === '0, "R5 zero first operand", val_out(prod_out), 0);
    apply(TA[4], '0);
    check(prod_out === '0, "R5 zero second operand", val_out(prod_out), 0);

    apply(TA[2], TB[2]);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0, "R7 valid after reset", 192'(out_valid), 0);
    check(prod_out === '0, "R7 result cleared", val_out(prod_out), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule